// File: doc/BRIEF.md
# Gain Switching Threshold Indicators

This block generates the level flags that steer an external attenuator or gain stage in front of a converter. A coarse upper flag reacts quickly. It compares a 3-bit fast magnitude code with a 3-bit programmable level, so it can trigger an attenuator before the converter is driven into overload. Two fine flags compare the full 13-bit sample magnitude with separate upper and lower 13-bit thresholds. They give a decision at full resolution, which can be used to switch gain back up when the signal becomes quiet.

A threshold value T corresponds to a level of 20·log10(T/8192) dBFS. The block also delays an overrange input so that it lines up with the converter data. All thresholds are plain input ports that the surrounding logic holds steady. The block does not compute the fast magnitude code and has no register access.

Top module: `gain_level_flags`

## Requirements
- R1: The coarse condition is true when `fast_code` is strictly greater than `coarse_lvl`, both taken as unsigned 3-bit values. When the code equals the level, the condition is false.
- R2: `coarse_hi` rises exactly two clock edges after the first cycle in which the coarse condition is present on the inputs.
- R3: Once `coarse_hi` rises, it stays high for at least two cycles. After that it is high in a cycle only if the coarse condition was present two cycles earlier.
- R4: `fine_hi` reports that `mag` is strictly greater than `fine_hi_thr`, both unsigned 13-bit values.
- R5: `fine_lo` reports that `mag` is strictly less than `fine_lo_thr`, both unsigned 13-bit values.
- R6: Both fine flags are registered and reflect the inputs sampled one clock edge earlier.
- R7: `ovr_out` reproduces `ovr_in` delayed by exactly 12 clock edges.
- R8: A synchronous active-high `rst` clears all flags, the coarse hold state and the overrange delay line at the next edge.
- R9: With `coarse_lvl` = 0, every nonzero code sets the coarse condition. With `coarse_lvl` = 7, `coarse_hi` never asserts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst | input | 1 | Synchronous reset, active high |
| fast_code | input | 3 | Fast magnitude code |
| coarse_lvl | input | 3 | Coarse upper level |
| mag | input | 13 | Full-resolution sample magnitude |
| fine_hi_thr | input | 13 | Fine upper threshold |
| fine_lo_thr | input | 13 | Fine lower threshold |
| ovr_in | input | 1 | Overrange at the converter input |
| coarse_hi | output | 1 | Coarse upper flag |
| fine_hi | output | 1 | Fine upper flag |
| fine_lo | output | 1 | Fine lower flag |
| ovr_out | output | 1 | Overrange aligned with the data |

## Verification
For each of the eight coarse levels, the coarse path is driven with random 3-bit codes. This produces isolated one-cycle excursions, which show the minimum hold, as well as long runs, which show the release timing. A separate pass sets the code equal to the level to expose an off-by-one in the comparison. The ends of the level range are checked on their own (level 0 and level 7).

The fine flags are driven with magnitudes at one below, equal to and one above each threshold, so that strict and inclusive comparisons give different results. Random overrange pulses confirm the twelve-cycle alignment. A reset issued in the middle of a run confirms that the delay line is cleared.

// File: rtl/gain_level_flags.sv
module gain_level_flags #(
  parameter int MAG_W    = 13,
  parameter int CODE_W   = 3,
  parameter int OVR_LAT  = 12,
  parameter int HOLD_MIN = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] fast_code,
  input  logic [CODE_W-1:0] coarse_lvl,
  input  logic [MAG_W-1:0]  mag,
  input  logic [MAG_W-1:0]  fine_hi_thr,
  input  logic [MAG_W-1:0]  fine_lo_thr,
  input  logic              ovr_in,
  output logic              coarse_hi,
  output logic              fine_hi,
  output logic              fine_lo,
  output logic              ovr_out
);

  localparam int CNT_W = $clog2(HOLD_MIN + 1);

  logic               exceed, exc_d1, hold, c_next;
  logic [CNT_W-1:0]   run_cnt;
  logic [OVR_LAT-1:0] ovr_sr;

  assign exceed  = fast_code > coarse_lvl;
  assign hold    = coarse_hi && (run_cnt < CNT_W'(HOLD_MIN));
  assign c_next  = exc_d1 || hold;
  assign ovr_out = ovr_sr[OVR_LAT-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      exc_d1    <= 1'b0;
      coarse_hi <= 1'b0;
      run_cnt   <= '0;
      fine_hi   <= 1'b0;
      fine_lo   <= 1'b0;
      ovr_sr    <= '0;
    end else begin
      exc_d1    <= exceed;
      coarse_hi <= c_next;
      if (!c_next)
        run_cnt <= '0;
      else if (run_cnt != CNT_W'(HOLD_MIN))
        run_cnt <= run_cnt + 1'b1;
      fine_hi   <= mag > fine_hi_thr;
      fine_lo   <= mag < fine_lo_thr;
      ovr_sr    <= {ovr_sr[OVR_LAT-2:0], ovr_in};
    end
  end

  a_r2_coarse_latency: assert property (@(posedge clk) disable iff (rst)
    exceed |-> ##2 coarse_hi);
  a_r3_min_hold: assert property (@(posedge clk) disable iff (rst)
    $rose(coarse_hi) |=> coarse_hi);
  a_r3_release: assert property (@(posedge clk) disable iff (rst)
    (coarse_hi && $past(coarse_hi) && !exc_d1) |=> !coarse_hi);
  a_r4_fine_hi: assert property (@(posedge clk) disable iff (rst)
    (mag > fine_hi_thr) |=> fine_hi);
  a_r5_fine_lo: assert property (@(posedge clk) disable iff (rst)
    (mag >= fine_lo_thr) |=> !fine_lo);
  a_r7_ovr_align: assert property (@(posedge clk) disable iff (rst)
    ovr_in |-> ##OVR_LAT ovr_out);
  a_r8_reset_clear: assert property (@(posedge clk)
    rst |=> !(coarse_hi || fine_hi || fine_lo || ovr_out));

endmodule

// File: tb/gain_level_flags_tb.sv
module gain_level_flags_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] fast_code = '0, coarse_lvl = '0;
  logic [12:0] mag = '0, fine_hi_thr = '0, fine_lo_thr = '0;
  logic ovr_in = 1'b0;
  logic coarse_hi, fine_hi, fine_lo, ovr_out;

  int total = 0, bad = 0;
  bit done = 0;

  logic e1, e2, c1, c2;
  logic [11:0] oh;
  logic [12:0] p_mag, p_hthr, p_lthr;

  always #2 clk = ~clk;

  gain_level_flags u_dut (
    .clk(clk), .rst(rst), .fast_code(fast_code), .coarse_lvl(coarse_lvl),
    .mag(mag), .fine_hi_thr(fine_hi_thr), .fine_lo_thr(fine_lo_thr),
    .ovr_in(ovr_in), .coarse_hi(coarse_hi), .fine_hi(fine_hi),
    .fine_lo(fine_lo), .ovr_out(ovr_out)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s t=%0t actual=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  task automatic clear_model();
    e1 = 0; e2 = 0; c1 = 0; c2 = 0; oh = '0;
    p_mag = '0; p_hthr = '0; p_lthr = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; fast_code = 0; coarse_lvl = 0; mag = 0;
    fine_hi_thr = 0; fine_lo_thr = 0; ovr_in = 0;
    @(negedge clk);
    @(negedge clk);
    rst = 0;
    clear_model();
    chk("R8 coarse", coarse_hi, 1'b0);
    chk("R8 fine_hi", fine_hi, 1'b0);
    chk("R8 fine_lo", fine_lo, 1'b0);
    chk("R8 ovr", ovr_out, 1'b0);
  endtask

  task automatic step(input string ctag, input logic [2:0] code, input logic [2:0] lvl,
                      input logic [12:0] m, input logic [12:0] ht, input logic [12:0] lt,
                      input logic ov);
    logic expc;
    @(negedge clk);
    expc = e2 || (c1 && !c2);
    chk(ctag, coarse_hi, expc);
    chk("R4/R6 fine_hi", fine_hi, p_mag > p_hthr);
    chk("R5/R6 fine_lo", fine_lo, p_mag < p_lthr);
    chk("R7 ovr", ovr_out, oh[11]);
    c2 = c1; c1 = expc; e2 = e1; e1 = (code > lvl);
    oh = {oh[10:0], ov};
    p_mag = m; p_hthr = ht; p_lthr = lt;
    fast_code = code; coarse_lvl = lvl; mag = m;
    fine_hi_thr = ht; fine_lo_thr = lt; ovr_in = ov;
  endtask

  initial begin
    clear_model();
    repeat (2) @(negedge clk);
    do_reset();

    for (int lv = 0; lv < 8; lv++)
      for (int n = 0; n < 80; n++)
        step("R2/R3 coarse", 3'($urandom % 8), 3'(lv), 13'($urandom), 13'($urandom),
             13'($urandom), 1'($urandom % 5 == 0));

    for (int lv = 0; lv < 8; lv++)
      for (int n = 0; n < 6; n++)
        step("R1 coarse equal", 3'(lv), 3'(lv), '0, '0, '0, 1'b0);

    for (int n = 0; n < 8; n++) begin
      step("R9 level7", 3'(n), 3'd7, '0, '0, '0, 1'b0);
      step("R9 level7", 3'd7, 3'd7, '0, '0, '0, 1'b0);
    end
    for (int n = 0; n < 24; n++)
      step("R9 level0", 3'(n % 8), 3'd0, '0, '0, '0, 1'b0);

    for (int n = 0; n < 600; n++) begin
      int t, d;
      t = 1 + ($urandom % 8190);
      d = int'($urandom % 3) - 1;
      step("R3 coarse", 3'($urandom % 8), 3'($urandom % 8), 13'(t + d), 13'(t),
           13'(t + int'($urandom % 3) - 1), 1'($urandom % 3 == 0));
    end

    for (int n = 0; n < 4; n++) step("R3 coarse", 3'd0, 3'd0, '0, '0, '0, 1'b1);
    do_reset();
    for (int n = 0; n < 14; n++) step("R8 coarse", 3'd0, 3'd0, '0, '0, '0, 1'b0);

    for (int n = 0; n < 14; n++) step("R2 coarse", 3'd0, 3'd0, '0, '0, '0, 1'b0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule